// File: doc/BRIEF.md
# Programmed-I/O Byte Buffer with Drain Collapse

This block is the byte staging store that sits between a host register port and the transfer sequencer of a storage bus controller when data moves one byte at a time under software control. Host writes deposit bytes into a linear data array, and host reads remove them in order. Reads are allowed only when the bus phase code says that data is flowing toward the host. Whenever the read index catches up with the write index, both indices return to zero. The array therefore never wraps, and the last slot is never filled.

While a command is being gathered, the host's byte writes are redirected into a separate, bounded command store and the data array is left alone. The sequencer can also preload a two-byte status reply, or clear all transfer state when a new selection begins. Alongside the data, the block keeps a signed residual byte counter and an occupancy count. A one-cycle overrun pulse reports any byte that had to be thrown away.

Top module: `pio_byte_fifo`

## Requirements
- R1: After a synchronous reset, `fifo_count`, `resid_size`, `cmd_len`, `rd_data` and `overrun` are all zero.
- R2: With `cmd_mode` low, a write whose write index is below DEPTH-1 stores `wr_data` at that index. The index advances, and both `resid_size` and `fifo_count` increase by one on the next clock.
- R3: With `cmd_mode` low, a write arriving while the write index equals DEPTH-1 is dropped. `overrun` is high for exactly the following cycle, and the count and residual are unchanged.
- R4: A read with `phase` equal to 3'b000 pops nothing. `rd_data` becomes 0 and the residual is unchanged.
- R5: A read with a nonzero `phase` while the read index is below the write index returns the oldest byte on `rd_data` one clock later and decrements `resid_size` and `fifo_count`.
- R6: A read with a nonzero `phase` while the buffer holds nothing leaves `rd_data`, `resid_size` and `fifo_count` unchanged.
- R7: After any read, if the read index equals the write index, both indices return to zero. The overrun point depends on the write index and not on occupancy, so after a partial drain a write can still overrun while fewer than DEPTH-1 bytes are held.
- R8: With `cmd_mode` high, a write appends to the command store while `cmd_len` is below CMD_DEPTH. Stored bytes read back through `cmd_idx`/`cmd_byte` with one clock of latency. Past capacity, the byte is dropped with an `overrun` pulse. The data array, count and residual are untouched either way.
- R9: `status_load` places `status_byte` at index 0 and a zero byte at index 1, sets the read index to 0 and the write index to 2, and sets `resid_size` and `fifo_count` to 2.
- R10: `sel_start` clears both indices, `resid_size`, `fifo_count` and `cmd_len`. Same-cycle requests are served in the priority order `sel_start`, then `status_load`, then write, then read.
- R11: When a write and a read arrive in the same cycle, only the write takes effect, and `rd_data` keeps its previous value.
- R12: `fifo_count` always equals the write index minus the read index and never exceeds DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Byte written by the host |
| rd_en | input | 1 | Host byte read strobe |
| cmd_mode | input | 1 | Redirects writes to the command store |
| phase | input | 3 | Bus phase code; 0 means data flows away from the host |
| status_load | input | 1 | Preload the status reply |
| status_byte | input | 8 | Status byte for the reply |
| sel_start | input | 1 | Start of a new selection; clears transfer state |
| cmd_idx | input | $clog2(CMD_DEPTH) | Command store read index |
| rd_data | output | 8 | Registered read byte |
| cmd_byte | output | 8 | Registered command store byte at `cmd_idx` |
| overrun | output | 1 | One-cycle pulse for a dropped byte |
| fifo_count | output | $clog2(DEPTH)+1 | Bytes held (write index minus read index) |
| resid_size | output | SIZE_W | Signed residual transfer size |
| cmd_len | output | $clog2(CMD_DEPTH+1) | Bytes held in the command store |

## Verification
Index errors do not stay hidden for long. A read index that fails to collapse, or a write index that collapses too early, moves the point where the next write overruns. It also makes `fifo_count` disagree with the running tally within a cycle. A wrong read address returns a byte out of order on the very next read. Bad priority or steering shows up one clock after the conflicting strobes, as a count, residual or `cmd_len` that moved when it should not have. The stimulus deliberately drives the partial-drain-then-refill pattern, because only there does the linear overrun rule differ from a plain occupancy check.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  localparam int PHASE_W = 3;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SEL,
    OP_STATUS,
    OP_PUSH,
    OP_CMD,
    OP_POP,
    OP_RDZ
  } op_e;

  // Fixed service priority: selection, status preload, write, read.
  function automatic op_e decode_op(input logic sel, input logic sl,
                                    input logic wr, input logic cm,
                                    input logic rd, input logic [PHASE_W-1:0] ph);
    if (sel)      return OP_SEL;
    else if (sl)  return OP_STATUS;
    else if (wr)  return cm ? OP_CMD : OP_PUSH;
    else if (rd)  return (ph == '0) ? OP_RDZ : OP_POP;
    else          return OP_IDLE;
  endfunction
endpackage

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int SIZE_W    = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int CLEN_W = $clog2(CMD_DEPTH + 1),
  localparam int CIDX_W = $clog2(CMD_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  op_e                      op,
  output logic                     store_en,
  output logic [PTR_W-1:0]         store_addr,
  output logic                     pop_en,
  output logic                     zero_rd,
  output logic [PTR_W-1:0]         pop_addr,
  output logic                     cmd_we,
  output logic [CIDX_W-1:0]        cmd_waddr,
  output logic                     overrun,
  output logic [CNT_W-1:0]         count,
  output logic signed [SIZE_W-1:0] size,
  output logic [CLEN_W-1:0]        cmd_len
);
  localparam logic [PTR_W-1:0]  LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CLEN_W-1:0] CMD_CAP  = CLEN_W'(CMD_DEPTH);

  logic [PTR_W-1:0] rp, wp, rp_inc, wp_inc;
  logic             can_pop, data_full, cmd_full;

  always_comb begin
    rp_inc    = rp + PTR_W'(1);
    wp_inc    = wp + PTR_W'(1);
    can_pop   = (rp < wp);
    data_full = (wp == LAST_IDX);
    cmd_full  = (cmd_len >= CMD_CAP);
    store_en  = (op == OP_PUSH) && !data_full;
    store_addr = wp;
    pop_en    = (op == OP_POP) && can_pop;
    zero_rd   = (op == OP_RDZ);
    pop_addr  = rp;
    cmd_we    = (op == OP_CMD) && !cmd_full;
    cmd_waddr = CIDX_W'(cmd_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rp <= '0; wp <= '0; count <= '0; size <= '0;
      cmd_len <= '0; overrun <= 1'b0;
    end else begin
      overrun <= 1'b0;
      unique case (op)
        OP_SEL: begin
          rp <= '0; wp <= '0; count <= '0; size <= '0; cmd_len <= '0;
        end
        OP_STATUS: begin
          rp <= '0; wp <= PTR_W'(2); count <= CNT_W'(2); size <= SIZE_W'(2);
        end
        OP_PUSH: begin
          if (data_full) overrun <= 1'b1;
          else begin
            wp <= wp_inc; count <= count + CNT_W'(1); size <= size + SIZE_W'(1);
          end
        end
        OP_CMD: begin
          if (cmd_full) overrun <= 1'b1;
          else cmd_len <= cmd_len + CLEN_W'(1);
        end
        OP_POP: begin
          if (can_pop) begin
            count <= count - CNT_W'(1); size <= size - SIZE_W'(1);
            if (rp_inc == wp) begin rp <= '0; wp <= '0; end
            else rp <= rp_inc;
          end else if (rp == wp) begin
            rp <= '0; wp <= '0;
          end
        end
        OP_RDZ: begin
          if (rp == wp) begin rp <= '0; wp <= '0; end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pio_fifo_ram.sv
module pio_fifo_ram #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic             preload,
  input  logic [7:0]       preload_byte,
  input  logic             re,
  input  logic             zero_rd,
  input  logic [PTR_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (preload) begin
      mem[0] <= preload_byte;
      mem[1] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= 8'h00;
    else if (zero_rd) rdata <= 8'h00;
    else if (re)      rdata <= mem[raddr];
  end
endmodule

// File: rtl/pio_cmd_buf.sv
module pio_cmd_buf #(
  parameter int CMD_DEPTH = 16,
  localparam int CIDX_W = $clog2(CMD_DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [CIDX_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [CIDX_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [CMD_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int SIZE_W    = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int CLEN_W = $clog2(CMD_DEPTH + 1),
  localparam int CIDX_W = $clog2(CMD_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [7:0]               wr_data,
  input  logic                     rd_en,
  input  logic                     cmd_mode,
  input  logic [PHASE_W-1:0]       phase,
  input  logic                     status_load,
  input  logic [7:0]               status_byte,
  input  logic                     sel_start,
  input  logic [CIDX_W-1:0]        cmd_idx,
  output logic [7:0]               rd_data,
  output logic [7:0]               cmd_byte,
  output logic                     overrun,
  output logic [CNT_W-1:0]         fifo_count,
  output logic signed [SIZE_W-1:0] resid_size,
  output logic [CLEN_W-1:0]        cmd_len
);
  op_e               op;
  logic              store_en, pop_en, zero_rd, cmd_we;
  logic [PTR_W-1:0]  store_addr, pop_addr;
  logic [CIDX_W-1:0] cmd_waddr;

  assign op = decode_op(sel_start, status_load, wr_en, cmd_mode, rd_en, phase);

  pio_fifo_ctrl #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rst(rst), .op(op),
    .store_en(store_en), .store_addr(store_addr),
    .pop_en(pop_en), .zero_rd(zero_rd), .pop_addr(pop_addr),
    .cmd_we(cmd_we), .cmd_waddr(cmd_waddr),
    .overrun(overrun), .count(fifo_count), .size(resid_size), .cmd_len(cmd_len)
  );

  pio_fifo_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst),
    .we(store_en), .waddr(store_addr), .wdata(wr_data),
    .preload(op == OP_STATUS), .preload_byte(status_byte),
    .re(pop_en), .zero_rd(zero_rd), .raddr(pop_addr), .rdata(rd_data)
  );

  pio_cmd_buf #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk(clk), .we(cmd_we), .waddr(cmd_waddr), .wdata(wr_data),
    .raddr(cmd_idx), .rdata(cmd_byte)
  );
endmodule

// File: rtl/pio_byte_fifo_chk.sv
module pio_byte_fifo_chk #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int SIZE_W    = 16,
  localparam int CNT_W  = $clog2(DEPTH) + 1,
  localparam int CLEN_W = $clog2(CMD_DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic                     cmd_mode,
  input logic [2:0]               phase,
  input logic                     status_load,
  input logic                     sel_start,
  input logic [7:0]               rd_data,
  input logic                     overrun,
  input logic [CNT_W-1:0]         fifo_count,
  input logic signed [SIZE_W-1:0] resid_size,
  input logic [CLEN_W-1:0]        cmd_len
);
  // R3
  overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> ($past(wr_en) && !$past(sel_start) && !$past(status_load)));
  // R4
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !sel_start && !status_load && phase == 3'b000)
      |=> (rd_data == 8'h00 && resid_size == $past(resid_size)));
  // R8
  cmd_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cmd_mode && !sel_start && !status_load)
      |=> ($stable(fifo_count) && $stable(resid_size)));
  // R8
  cmd_len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_len <= CLEN_W'(CMD_DEPTH));
  // R9
  status_preload_chk: assert property (@(posedge clk) disable iff (rst)
    (status_load && !sel_start) |=> (fifo_count == CNT_W'(2) && resid_size == SIZE_W'(2)));
  // R10
  sel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sel_start |=> (fifo_count == '0 && resid_size == '0 && cmd_len == '0));
  // R11
  write_beats_read_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !cmd_mode && !sel_start && !status_load) |=> $stable(rd_data));
  // R12
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(DEPTH - 1));
endmodule

bind pio_byte_fifo pio_byte_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/sim_pio_byte_fifo.sv
module sim_pio_byte_fifo;
  localparam int D  = 16;
  localparam int CD = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, cmd_mode = 0, status_load = 0, sel_start = 0;
  logic [7:0] wr_data = 0, status_byte = 0;
  logic [2:0] phase = 0;
  logic [3:0] cmd_idx = 0;
  logic [7:0] rd_data, cmd_byte;
  logic overrun;
  logic [4:0] fifo_count, cmd_len;
  logic signed [15:0] resid_size;

  always #5 clk = ~clk;

  pio_byte_fifo #(.DEPTH(D), .CMD_DEPTH(CD), .SIZE_W(16)) u0 (.*);

  typedef struct packed {
    logic [7:0]  rd;
    logic [15:0] size;
    logic [4:0]  cnt;
    logic        ovr;
    logic [4:0]  clen;
    logic        chk_cmd;
    logic [7:0]  cmdv;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int errors = 0, checks = 0;
  bit done = 0;

  // Reference state built from the requirements.
  logic [7:0] m_mem [D];
  logic [7:0] m_cmd [CD];
  int m_rp = 0, m_wp = 0, m_size = 0, m_clen = 0;
  logic [7:0] m_rd = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, updates the model, queues the expectation.
  task automatic step(input bit w, input bit r, input bit cm, input bit sl, input bit sel,
                      input logic [2:0] ph, input logic [7:0] d, input logic [7:0] st,
                      input bit peek, input logic [3:0] idx, input string tag);
    exp_t e;
    bit ovr = 0;
    @(negedge clk);
    wr_en = w; rd_en = r; cmd_mode = cm; status_load = sl; sel_start = sel;
    phase = ph; wr_data = d; status_byte = st; cmd_idx = idx;
    if (sel) begin
      m_rp = 0; m_wp = 0; m_size = 0; m_clen = 0;
    end else if (sl) begin
      m_mem[0] = st; m_mem[1] = 8'h00; m_rp = 0; m_wp = 2; m_size = 2;
    end else if (w) begin
      if (cm) begin
        if (m_clen < CD) begin m_cmd[m_clen] = d; m_clen++; end
        else ovr = 1;
      end else if (m_wp == D - 1) ovr = 1;
      else begin m_mem[m_wp] = d; m_wp++; m_size++; end
    end else if (r) begin
      if (ph == 3'b000) m_rd = 8'h00;
      else if (m_rp < m_wp) begin m_rd = m_mem[m_rp]; m_rp++; m_size--; end
      if (m_rp == m_wp) begin m_rp = 0; m_wp = 0; end
    end
    e.rd = m_rd; e.size = 16'(m_size); e.cnt = 5'(m_wp - m_rp); e.ovr = ovr;
    e.clen = 5'(m_clen); e.chk_cmd = peek; e.cmdv = peek ? m_cmd[idx] : 8'h00;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; rd_en = 0; cmd_mode = 0; status_load = 0; sel_start = 0; phase = 0;
  endtask

  task automatic push(input logic [7:0] d, input string tag);
    step(1, 0, 0, 0, 0, 3'd0, d, 8'h00, 0, 4'd0, tag);
  endtask
  task automatic pop(input logic [2:0] ph, input string tag);
    step(0, 1, 0, 0, 0, ph, 8'h00, 8'h00, 0, 4'd0, tag);
  endtask

  // Monitor: one expectation per driven cycle, sampled 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      exp_t e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      check(rd_data == e.rd, t, "rd_data", rd_data, e.rd);
      check(resid_size == $signed(e.size), t, "resid_size", resid_size, $signed(e.size));
      check(fifo_count == e.cnt, {t, "/R12"}, "fifo_count", fifo_count, e.cnt);
      check(overrun == e.ovr, t, "overrun", overrun, e.ovr);
      check(cmd_len == e.clen, t, "cmd_len", cmd_len, e.clen);
      if (e.chk_cmd) check(cmd_byte == e.cmdv, t, "cmd_byte", cmd_byte, e.cmdv);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check(fifo_count == 0 && resid_size == 0 && cmd_len == 0, "R1", "counters", fifo_count, 0);
    check(rd_data == 0 && overrun == 0, "R1", "rd_data/overrun", rd_data, 0);

    // R2 push, R5 in-order pop, R4 zero-phase read
    push(8'hA0, "R2"); push(8'hA1, "R2"); push(8'hA2, "R2");
    pop(3'd1, "R5");
    pop(3'd0, "R4");
    pop(3'd3, "R5"); pop(3'd1, "R5/R7");
    pop(3'd1, "R6");
    pop(3'd0, "R4"); pop(3'd2, "R6");

    // R3 overrun at index DEPTH-1
    for (int i = 0; i < D - 1; i++) push(8'(8'h10 + i), "R2");
    push(8'hEE, "R3");
    idle();
    // R7 linear rule: partial drain does not free room
    pop(3'd1, "R5"); pop(3'd1, "R5"); pop(3'd1, "R5");
    push(8'hEF, "R7");
    for (int i = 0; i < D - 4; i++) pop(3'd1, "R7");
    push(8'h55, "R7");
    push(8'h56, "R7");

    // R11 write beats read
    step(1, 1, 0, 0, 0, 3'd1, 8'h57, 8'h00, 0, 4'd0, "R11");
    pop(3'd1, "R5");

    // R8 command steering
    for (int i = 0; i < CD; i++)
      step(1, 0, 1, 0, 0, 3'd0, 8'(8'hC0 + i), 8'h00, 0, 4'd0, "R8");
    step(1, 0, 1, 0, 0, 3'd0, 8'hFF, 8'h00, 0, 4'd0, "R8");
    idle();
    step(0, 0, 0, 0, 0, 3'd0, 8'h00, 8'h00, 1, 4'd0, "R8");
    step(0, 0, 0, 0, 0, 3'd0, 8'h00, 8'h00, 1, 4'd7, "R8");
    step(0, 0, 0, 0, 0, 3'd0, 8'h00, 8'h00, 1, 4'd15, "R8");

    // R9 status preload
    step(0, 0, 0, 1, 0, 3'd0, 8'h00, 8'h3C, 0, 4'd0, "R9");
    pop(3'd3, "R9"); pop(3'd3, "R9");
    push(8'h77, "R9");

    // R10 selection clears and has top priority
    push(8'h78, "R10");
    step(1, 0, 1, 1, 1, 3'd1, 8'h99, 8'h12, 0, 4'd0, "R10");
    step(1, 1, 0, 1, 0, 3'd1, 8'h98, 8'h34, 0, 4'd0, "R10");
    pop(3'd1, "R10");
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(expq.size() == 0, "R1", "queue drained", expq.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule